// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

This block keeps a 48-bit running count that advances by one on every pulse of a 32768 Hz tick enable. The low 15 bits hold fractions of a second, and bits 47:15 hold whole seconds. Software sees the count as three 16-bit halfwords. A second set of three halfwords holds an alarm value laid out the same way.

Each time the count steps, the block compares the stepped value with the alarm value. When they are equal and the alarm value is non-zero, the block sets a sticky alarm flag. Software clears the flag by writing a one to it. An interrupt line follows the flag, gated by an enable bit.

Access is through a plain synchronous register port. It has a byte address, a write strobe and write data. Read data is combinational from the address. The whole count steps in one clock edge, so a carry never shows in one halfword before the others. Software can therefore read the three halfwords twice and accept the value when both reads agree.

Top module: `elapsed_alarm_timer`

Register map (byte addresses, 16-bit registers; address bit 0 is ignored):
0x00 count bits 15:0, 0x02 count bits 31:16, 0x04 count bits 47:32, 0x08 alarm bits 15:0, 0x0A alarm bits 31:16, 0x0C alarm bits 47:32, 0x10 status (bit 0 alarm flag), 0x12 control (bit 0 interrupt enable). Every other address reads as zero, and writes to it are dropped.

## Requirements
- R1: After reset the count, the alarm value, the alarm flag and the enable bit are zero, every register reads 0, and irq_out is low.
- R2: In a cycle with tick high and no write to a count halfword, the count rises by exactly one. In a cycle with tick low and no count write, the count holds.
- R3: A step is applied to all 48 bits at once. From low=0xFFFF and middle=0xFFFF, one step reads back as low=0, middle=0, high incremented by one. From all ones, one step wraps the count to zero.
- R4: A write to one count halfword (0x00, 0x02 or 0x04) replaces only that halfword, as of the next clock edge. A tick in the same cycle is ignored, so the written value is not incremented and the other halfwords keep their values.
- R5: The alarm halfwords at 0x08, 0x0A and 0x0C read back what was written. Reads from unmapped addresses return 0.
- R6: When a step makes the count equal to a non-zero alarm value, bit 0 of status (0x10) reads 1 from the next edge onward. With the count starting at 0 and alarm value t, the flag is 0 after t-1 steps and 1 after t steps.
- R7: An alarm value of all zeros never sets the flag, including when the count wraps to zero.
- R8: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves the flag unchanged. If a match occurs in the same cycle as a clear, the flag stays set.
- R9: irq_out is high exactly when the flag is set and control bit 0 (0x12) is 1. Control bit 0 reads back as written.
- R10: A bus write that makes the count equal the alarm value does not set the flag. Only a tick step is compared.
- R11: Whole seconds s occupy the count as follows: s bit 0 in low bit 15, s bits 16:1 in the middle halfword, and s bits 32:17 in the high halfword. After 32768 steps from a fraction of zero, the seconds read back as s+1 with a fraction of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | 32768 Hz step enable, one clock wide per step |
| bus_addr | input | 5 | Byte address of the 16-bit register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_out | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The alarm is swept over small targets from 1 to 10 with the count starting at zero. The flag is checked one step before and exactly at each target, which separates an off-by-one compare from a correct one. Carry patterns (low-halfword overflow, two-halfword overflow, full wrap) separate an atomic 48-bit step from per-halfword counting. Writes made together with a tick, a write landing on the alarm value, and a clear made together with a match each separate the ordering rules of the block. A full second of ticks from a known seconds value checks the bit layout of seconds across the three halfwords.

// File: rtl/etc_pkg.sv
package etc_pkg;
    // Register indices, taken from byte address bits [4:1]
    localparam int CNT_BASE  = 0;
    localparam int CMP_BASE  = 4;
    localparam int STAT_IDX  = 8;
    localparam int CTRL_IDX  = 9;
    // Bit positions inside status and control
    localparam int FLAG_BIT  = 0;
    localparam int EN_BIT    = 0;
endpackage

// File: rtl/etc_counter.sv
module etc_counter
    import etc_pkg::*;
#(
    parameter int HW_W = 16,
    parameter int NHW  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NHW-1:0]       cnt_we,
    input  logic [HW_W-1:0]      wdata,
    output logic [NHW*HW_W-1:0]  cnt_q,
    output logic [NHW*HW_W-1:0]  cnt_nxt,
    output logic                 step
);
    localparam int CNT_W = NHW * HW_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (|cnt_we) begin
            for (int i = 0; i < NHW; i++) begin
                if (cnt_we[i]) st_d.cnt[i*HW_W +: HW_W] = wdata;
            end
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            step     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q   = st_q.cnt;
    assign cnt_nxt = st_d.cnt;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_we == '0) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cnt_we == '0) |=> $stable(cnt_q));

    // R4
    cnt_wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we == NHW'(1)) |=> (cnt_q[HW_W-1:0] == $past(wdata)) &&
                                (cnt_q[CNT_W-1:HW_W] == $past(cnt_q[CNT_W-1:HW_W])));
endmodule

// File: rtl/etc_alarm.sv
module etc_alarm
    import etc_pkg::*;
#(
    parameter int HW_W = 16,
    parameter int NHW  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NHW-1:0]       cmp_we,
    input  logic                 stat_we,
    input  logic                 ctrl_we,
    input  logic [HW_W-1:0]      wdata,
    input  logic                 step,
    input  logic [NHW*HW_W-1:0]  cnt_nxt,
    output logic [NHW*HW_W-1:0]  cmp_q,
    output logic                 flag_q,
    output logic                 en_q
);
    localparam int CNT_W = NHW * HW_W;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             en;
    } alarm_state_t;

    alarm_state_t st_d, st_q;
    logic         hit;
    logic         clr_req;

    always_comb begin
        st_d    = st_q;
        hit     = step && (st_q.cmp != '0) && (cnt_nxt == st_q.cmp);
        clr_req = stat_we && wdata[FLAG_BIT];
        for (int i = 0; i < NHW; i++) begin
            if (cmp_we[i]) st_d.cmp[i*HW_W +: HW_W] = wdata;
        end
        if (ctrl_we) st_d.en   = wdata[EN_BIT];
        if (clr_req) st_d.flag = 1'b0;
        if (hit)     st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_q  = st_q.cmp;
    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;

    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(step));

    // R7
    zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cmp_q) != '0);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && wdata[FLAG_BIT] && !step) |=> !flag_q);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(stat_we && wdata[FLAG_BIT])) |=> flag_q);
endmodule

// File: rtl/etc_regbus.sv
module etc_regbus
    import etc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int HW_W   = 16,
    parameter int NHW    = 3
) (
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [NHW*HW_W-1:0]  cnt_q,
    input  logic [NHW*HW_W-1:0]  cmp_q,
    input  logic                 flag_q,
    input  logic                 en_q,
    output logic [NHW-1:0]       cnt_we,
    output logic [NHW-1:0]       cmp_we,
    output logic                 stat_we,
    output logic                 ctrl_we,
    output logic [HW_W-1:0]      rdata
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[ADDR_W-1:1];

    for (genvar g = 0; g < NHW; g++) begin : g_we
        assign cnt_we[g] = bus_wr && (idx == IDX_W'(CNT_BASE + g));
        assign cmp_we[g] = bus_wr && (idx == IDX_W'(CMP_BASE + g));
    end

    assign stat_we = bus_wr && (idx == IDX_W'(STAT_IDX));
    assign ctrl_we = bus_wr && (idx == IDX_W'(CTRL_IDX));

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NHW; i++) begin
            if (idx == IDX_W'(CNT_BASE + i)) rdata = cnt_q[i*HW_W +: HW_W];
            if (idx == IDX_W'(CMP_BASE + i)) rdata = cmp_q[i*HW_W +: HW_W];
        end
        if (idx == IDX_W'(STAT_IDX)) rdata[FLAG_BIT] = flag_q;
        if (idx == IDX_W'(CTRL_IDX)) rdata[EN_BIT]   = en_q;
    end
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer
    import etc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int HW_W   = 16,
    parameter int NHW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [HW_W-1:0]   bus_wdata,
    output logic [HW_W-1:0]   bus_rdata,
    output logic              irq_out
);
    localparam int CNT_W = NHW * HW_W;

    logic [NHW-1:0]   cnt_we, cmp_we;
    logic             stat_we, ctrl_we;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, cmp_q;
    logic             step, flag_q, en_q;

    etc_regbus #(.ADDR_W(ADDR_W), .HW_W(HW_W), .NHW(NHW)) u_regbus (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .cnt_q    (cnt_q),
        .cmp_q    (cmp_q),
        .flag_q   (flag_q),
        .en_q     (en_q),
        .cnt_we   (cnt_we),
        .cmp_we   (cmp_we),
        .stat_we  (stat_we),
        .ctrl_we  (ctrl_we),
        .rdata    (bus_rdata)
    );

    etc_counter #(.HW_W(HW_W), .NHW(NHW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_we  (cnt_we),
        .wdata   (bus_wdata),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .step    (step)
    );

    etc_alarm #(.HW_W(HW_W), .NHW(NHW)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_we  (cmp_we),
        .stat_we (stat_we),
        .ctrl_we (ctrl_we),
        .wdata   (bus_wdata),
        .step    (step),
        .cnt_nxt (cnt_nxt),
        .cmp_q   (cmp_q),
        .flag_q  (flag_q),
        .en_q    (en_q)
    );

    assign irq_out = flag_q & en_q;
endmodule

// File: tb/elapsed_alarm_timer_bench.sv
module elapsed_alarm_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    elapsed_alarm_timer u_elapsed_alarm_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input bit tk);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic wr_cnt(input logic [47:0] v);
        wr(5'h00, v[15:0], 1'b0);
        wr(5'h02, v[31:16], 1'b0);
        wr(5'h04, v[47:32], 1'b0);
    endtask

    task automatic wr_cmp(input logic [47:0] v);
        wr(5'h08, v[15:0], 1'b0);
        wr(5'h0A, v[31:16], 1'b0);
        wr(5'h0C, v[47:32], 1'b0);
    endtask

    task automatic rd_cnt(output logic [47:0] v);
        logic [15:0] h;
        rd(5'h00, h); v[15:0] = h;
        rd(5'h02, h); v[31:16] = h;
        rd(5'h04, h); v[47:32] = h;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [47:0] c;
        logic [32:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 32; a += 2) begin
            rd(5'(a), d);
            chk(d == 16'h0, "R1 reset read", d, 0);
        end
        #1 chk(irq_out == 1'b0, "R1 irq after reset", irq_out, 0);

        // R2: stepping and holding
        run_ticks(100);
        rd_cnt(c);
        chk(c == 48'd100, "R2 step count", c, 100);
        repeat (10) @(negedge clk);
        rd_cnt(c);
        chk(c == 48'd100, "R2 hold without tick", c, 100);

        // R4: write with concurrent tick is not incremented; others kept
        wr_cnt(48'h0005_0007_0000);
        wr(5'h00, 16'h1234, 1'b1);
        rd_cnt(c);
        chk(c == 48'h0005_0007_1234, "R4 write wins over tick", c, 48'h0005_0007_1234);
        run_ticks(1);
        rd_cnt(c);
        chk(c == 48'h0005_0007_1235, "R4 step after write", c, 48'h0005_0007_1235);
        wr(5'h02, 16'hABCD, 1'b1);
        rd_cnt(c);
        chk(c == 48'h0005_ABCD_1235, "R4 middle write only", c, 48'h0005_ABCD_1235);

        // R3: carries in one step
        wr_cnt(48'h0000_0005_FFFF);
        run_ticks(1);
        rd_cnt(c);
        chk(c == 48'h0000_0006_0000, "R3 low carry", c, 48'h0000_0006_0000);
        wr_cnt(48'h0003_FFFF_FFFF);
        run_ticks(1);
        rd_cnt(c);
        chk(c == 48'h0004_0000_0000, "R3 double carry", c, 48'h0004_0000_0000);

        // R7: zero alarm with wrap
        wr_cmp(48'h0);
        wr_cnt(48'hFFFF_FFFF_FFFF);
        run_ticks(1);
        rd_cnt(c);
        chk(c == 48'h0, "R3 full wrap", c, 0);
        rd(5'h10, d);
        chk(d == 16'h0, "R7 zero alarm no flag", d, 0);

        // R5: compare readback and unmapped reads
        wr_cmp(48'h1357_2468_9ABC);
        rd(5'h08, d); chk(d == 16'h9ABC, "R5 alarm low", d, 16'h9ABC);
        rd(5'h0A, d); chk(d == 16'h2468, "R5 alarm mid", d, 16'h2468);
        rd(5'h0C, d); chk(d == 16'h1357, "R5 alarm high", d, 16'h1357);
        for (int a = 6; a < 32; a += 2) begin
            if (a != 8 && a != 10 && a != 12 && a != 16 && a != 18) begin
                rd(5'(a), d);
                chk(d == 16'h0, "R5 unmapped read", d, 0);
            end
        end

        // R6: sweep of alarm targets
        for (int t = 1; t <= 10; t++) begin
            wr_cnt(48'h0);
            wr_cmp(48'(t));
            wr(5'h10, 16'h0001, 1'b0);
            run_ticks(t - 1);
            rd(5'h10, d);
            chk(d == 16'h0, "R6 flag before target", d, 0);
            run_ticks(1);
            rd(5'h10, d);
            chk(d == 16'h1, "R6 flag at target", d, 1);
        end

        // R9: interrupt gating
        #1 chk(irq_out == 1'b0, "R9 irq disabled", irq_out, 0);
        wr(5'h12, 16'h0001, 1'b0);
        rd(5'h12, d); chk(d == 16'h1, "R9 enable readback", d, 1);
        #1 chk(irq_out == 1'b1, "R9 irq enabled", irq_out, 1);

        // R8: write-one-to-clear
        wr(5'h10, 16'h0000, 1'b0);
        rd(5'h10, d); chk(d == 16'h1, "R8 write zero keeps", d, 1);
        wr(5'h10, 16'h0001, 1'b0);
        rd(5'h10, d); chk(d == 16'h0, "R8 write one clears", d, 0);
        #1 chk(irq_out == 1'b0, "R9 irq follows clear", irq_out, 0);
        wr_cmp(48'h10);
        wr_cnt(48'h0F);
        wr(5'h10, 16'h0001, 1'b1);
        rd(5'h10, d); chk(d == 16'h1, "R8 match beats clear", d, 1);
        wr(5'h12, 16'h0000, 1'b0);
        #1 chk(irq_out == 1'b0, "R9 irq gated off", irq_out, 0);

        // R10: a write reaching the alarm value does not set the flag
        wr(5'h10, 16'h0001, 1'b0);
        wr_cnt(48'h10);
        rd(5'h10, d); chk(d == 16'h0, "R10 write no match", d, 0);

        // R11: seconds layout across one full second
        s = 33'h1_2468_ACF1;
        wr(5'h00, {s[0], 15'h0}, 1'b0);
        wr(5'h02, s[16:1], 1'b0);
        wr(5'h04, s[32:17], 1'b0);
        run_ticks(32768);
        rd_cnt(c);
        chk(c[47:15] == s + 33'd1, "R11 seconds advance", c[47:15], s + 33'd1);
        chk(c[14:0] == 15'h0, "R11 fraction zero", c[14:0], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule